// File: doc/BRIEF.md
# Masked Interrupt Request Aggregator

The aggregator gathers eight interrupt sources into one level-sensitive request line for an upstream controller. Each source raises a bit in a pending register through a post vector and can withdraw it through a clear vector. A separate enable set, written by software over a byte-wide register bus, decides which pending bits may drive the request line.

Software sees the enable set inverted. A byte written to the mask register is stored as its complement, and a read of that register returns the complement of the stored value, so a 1 in the written byte blocks a source. Software acknowledges one interrupt by writing its index; only the low four bits count. A second mask register is plain storage that never touches the request line, and its status address always reads zero. The request line is registered and follows the state with one cycle of delay.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, pending is 0x00, the stored enable set is 0x00 (mask reads 0xFF), the secondary mask reads 0x00 and `irq_out` is low.
- R2: A write of D to the mask register (address 1) stores ~D as the enable set; a read of address 1 returns the complement of the stored enable set, i.e. D.
- R3: `post_vec` bits are ORed into pending on the clock edge they are sampled on.
- R4: `clear_vec` bits are removed from pending; when one bit is posted and cleared in the same cycle, the post wins and the bit stays set.
- R5: A write of D to the acknowledge address (address 2) clears pending bit D[3:0]; an index of 8 to 15 leaves pending unchanged.
- R6: A read of the status address (address 0) returns the raw pending register, whatever the enable set.
- R7: `irq_out` is high exactly when the pending register ANDed with the enable set was nonzero on the previous clock edge, so it follows posts, clears, acknowledges and mask writes one cycle later.
- R8: The secondary mask (address 4) stores and returns the written byte unchanged and never affects `irq_out`; its status address (address 3) always reads 0x00.
- R9: Reads of unused addresses (5 to 7) return 0x00, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_vec | input | 8 | Source bits to set in pending |
| clear_vec | input | 8 | Source bits to remove from pending |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (0 status, 1 mask, 2 ack, 3 secondary status, 4 secondary mask) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq_out | output | 1 | Level interrupt request to the upstream controller |

## Verification
Pending bits are built up from single-bit and multi-bit post patterns with masks of all-open, all-blocked and partial overlap, so that a correct output can be told apart from one that ignores the mask or leaves out the inversion. A cycle that posts and clears the same bit separates post priority from clear priority. Acknowledges with indices 0, 7 and 12 separate decoding of the low nibble from clearing with no bound check. Writes to the secondary mask while sources are pending show whether it leaks into the output.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int NSRC = 8,
  parameter int DW   = 8,
  parameter int AW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NSRC-1:0] post_vec,
  input  logic [NSRC-1:0] clear_vec,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_out
);
  localparam logic [AW-1:0] A_STAT  = AW'(0);
  localparam logic [AW-1:0] A_MASK  = AW'(1);
  localparam logic [AW-1:0] A_ACK   = AW'(2);
  localparam logic [AW-1:0] A_STAT2 = AW'(3);
  localparam logic [AW-1:0] A_MASK2 = AW'(4);

  logic [NSRC-1:0] pend, en;
  logic [DW-1:0]   mask2;
  logic [NSRC-1:0] ack_clr, pend_nx, en_nx;

  always_comb begin
    ack_clr = '0;
    if (bus_wr && bus_addr == A_ACK && int'(bus_wdata[3:0]) < NSRC)
      ack_clr[bus_wdata[3:0]] = 1'b1;
  end

  assign pend_nx = (pend & ~(clear_vec | ack_clr)) | post_vec;
  assign en_nx   = (bus_wr && bus_addr == A_MASK) ? ~bus_wdata[NSRC-1:0] : en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= '0;
      en      <= '0;
      mask2   <= '0;
      irq_out <= 1'b0;
    end else begin
      pend    <= pend_nx;
      en      <= en_nx;
      if (bus_wr && bus_addr == A_MASK2) mask2 <= bus_wdata;
      irq_out <= |(pend_nx & en_nx);
    end
  end

  always_comb begin
    case (bus_addr)
      A_STAT:  bus_rdata = DW'(pend);
      A_MASK:  bus_rdata = ~DW'(en);
      A_MASK2: bus_rdata = mask2;
      A_STAT2: bus_rdata = '0;
      default: bus_rdata = '0;
    endcase
  end

  assert_post_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (post_vec != '0) |=> ((pend & $past(post_vec)) == $past(post_vec)));
  assert_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (post_vec == '0 && clear_vec != '0) |=> ((pend & $past(clear_vec)) == '0));
  assert_irq_track_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == |(pend & en));
  assert_mask_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MASK) |=> (bus_rdata == $past(bus_wdata) || bus_addr != A_MASK));
  assert_stat2_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_STAT2) |-> (bus_rdata == '0));
  assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (post_vec == '0) |=> ((pend & ~$past(pend)) == '0));
endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  logic clk = 0, rst_n = 0;
  logic [7:0] post_vec = 0, clear_vec = 0, bus_wdata = 0, bus_rdata;
  logic bus_wr = 0, irq_out;
  logic [2:0] bus_addr = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_aggregator i_irq_aggregator (.clk, .rst_n, .post_vec, .clear_vec,
    .bus_wr, .bus_addr, .bus_wdata, .bus_rdata, .irq_out);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    post_vec = 0; clear_vec = 0; bus_wr = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1; step();
  endtask

  task automatic rd(logic [2:0] a, string req, logic [7:0] exp);
    bus_addr = a; #0.5; chk(req, bus_rdata, exp);
  endtask

  task automatic post(logic [7:0] v); post_vec = v; step(); endtask
  task automatic clr(logic [7:0] v); clear_vec = v; step(); endtask

  task automatic t_reset();
    rd(0, "R1 pend", 8'h00); rd(1, "R1 mask", 8'hFF); rd(4, "R1 mask2", 8'h00);
    chk("R1 irq", irq_out, 0);
  endtask

  task automatic t_mask_post();
    post(8'h05);
    rd(0, "R3 pend", 8'h05); chk("R7 blocked", irq_out, 0);
    wr(1, 8'hFE);
    rd(1, "R2 mask rd", 8'hFE); chk("R7 mask open", irq_out, 1);
    rd(0, "R6 raw", 8'h05);
    wr(1, 8'hFF); chk("R7 mask close", irq_out, 0);
    wr(1, 8'h00); chk("R7 all open", irq_out, 1);
  endtask

  task automatic t_clear();
    clr(8'h01); rd(0, "R4 clear", 8'h04); chk("R7 still", irq_out, 1);
    clr(8'h04); rd(0, "R4 clear all", 8'h00); chk("R7 clear drop", irq_out, 0);
    post_vec = 8'h10; clear_vec = 8'h10; step();
    rd(0, "R4 post wins", 8'h10); chk("R7 post wins", irq_out, 1);
  endtask

  task automatic t_ack();
    post(8'h81);
    wr(2, 8'hF7); rd(0, "R5 ack7", 8'h11);
    wr(2, 8'h0C); rd(0, "R5 ack12", 8'h11);
    wr(2, 8'h00); rd(0, "R5 ack0", 8'h10);
    wr(2, 8'h04); rd(0, "R5 ack4", 8'h00); chk("R7 ack drop", irq_out, 0);
  endtask

  task automatic t_second();
    wr(1, 8'hFF); post(8'h02);
    wr(4, 8'h00); rd(4, "R8 mask2", 8'h00); chk("R8 no irq", irq_out, 0);
    wr(4, 8'h5A); rd(4, "R8 mask2 b", 8'h5A); rd(3, "R8 stat2", 8'h00);
    wr(6, 8'h00); rd(1, "R9 mask kept", 8'hFF); rd(0, "R9 pend kept", 8'h02);
    rd(6, "R9 unused", 8'h00); chk("R9 irq", irq_out, 0);
  endtask

  initial begin
    #5000;
    if (!done) begin bad++; total++; $display("FAIL watchdog"); $display("test done: total=%0d bad=%0d", total, bad); $finish; end
  end

  initial begin
    step(); step(); rst_n = 1; #1;
    t_reset(); t_mask_post(); t_clear(); t_ack(); t_second();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule